// File: doc/BRIEF.md
# Programmable Clock Channel Divider

This block takes one input clock and produces one output clock at the input rate divided by an integer from 1 to 32. Two 4-bit fields set the output waveform. One sets the number of input cycles the output stays high and the other sets the number it stays low, so the total ratio is the sum of the two phases. A bypass bit passes the input clock straight through for divide-by-1, and the counting logic stays idle while it is set.

An optional duty-cycle correction stage is active whenever the disable input is low. If the low count is exactly one more than the high count, the ratio is odd, and the stage gives a 50% waveform by extending the high phase by half an input cycle on the falling input edge. For every other setting the plain counted waveform is used.

A sync pulse aligns several dividers. It forces the output low and starts a delay of a programmable number of input cycles before the first high phase. New settings are picked up only when a full output period begins, so changing them never produces a runt pulse.

Top module: `clk_chan_div`

## Requirements
- R1: While rst_n is low the output is low. At the first rising input edge after rst_n goes high, a period starts and the output goes high.
- R2: When not bypassed, the output period is hi_cnt + lo_cnt + 2 input cycles, which gives every ratio from 2 to 32.
- R3: Without correction, the output is high for hi_cnt + 1 input cycles and low for lo_cnt + 1 input cycles in each period. The high phase comes first and begins on a rising input edge.
- R4: With dcc_off = 0 and lo_cnt = hi_cnt + 1, the output is high for exactly half of the odd period. It rises on a rising input edge and falls on a falling input edge, hi_cnt + 1.5 input cycles later.
- R5: With bypass = 1, the output equals the input clock: high in the high half of each input cycle and low in the low half. The change into or out of bypass takes effect at the next period start.
- R6: A sync pulse sampled at a rising edge forces the output low at once. The output next rises at the (phase_ofs + 1)-th rising edge after that edge, so phase_ofs delays the first edge by that many whole input cycles.
- R7: Changes to hi_cnt, lo_cnt, bypass or dcc_off made during a period have no effect until the next period start. The current period finishes with its old high and low lengths.
- R8: With dcc_off = 1, the waveform is the uncorrected one of R3 for every setting, including lo_cnt = hi_cnt + 1. The high fraction is then (hi_cnt + 1)/(hi_cnt + lo_cnt + 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cnt | input | CW | High phase length minus one, in input cycles |
| lo_cnt | input | CW | Low phase length minus one, in input cycles |
| bypass | input | 1 | Pass the input clock through (divide by 1) |
| dcc_off | input | 1 | Disable the duty-cycle correction stage |
| phase_ofs | input | PW | Delay after sync, in whole input cycles |
| sync | input | 1 | Alignment pulse, sampled on rising input edges |
| clk_out | output | 1 | Divided output clock |

## Verification
The bench measures the period and the high time in half-cycles for all 256 high/low pairs, once with correction on and once with it off. A counter that is off by one shows up as a wrong period. A correction stage that fires on the wrong pairs, or that is not gated by dcc_off, shows up as a wrong number of high half-cycles. A reference model compares the output in both halves of every input cycle while settings change in the middle of a period and while bypass is toggled. A design that reloads settings at once would cut a period short and trip this comparison. Sync pulses with offsets 0, 3, 7 and 31 check the distance to the next rising edge, which exposes a delay that is off by one or an output that stays high after the pulse.

// File: rtl/clk_chan_div.sv
module clk_chan_div #(
  parameter int CW = 4,
  parameter int PW = 5
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic [CW-1:0] hi_cnt,
  input  logic [CW-1:0] lo_cnt,
  input  logic          bypass,
  input  logic          dcc_off,
  input  logic [PW-1:0] phase_ofs,
  input  logic          sync,
  output logic          clk_out
);
  localparam int DW = CW + 2;

  logic [CW-1:0] hi_a, lo_a;
  logic          byp_a, fix_a, started, pos_q, neg_q;
  logic [DW-1:0] pos_cnt;
  logic [PW-1:0] wait_cnt;

  wire [DW-1:0] d_last  = DW'(hi_a) + DW'(lo_a) + DW'(1);
  wire          fix_req = !dcc_off && ((CW+1)'(lo_cnt) == (CW+1)'(hi_cnt) + (CW+1)'(1));
  wire          p_end   = started && (byp_a || pos_cnt == d_last);
  wire          p_first = !started && wait_cnt == '0;
  wire          load    = p_end || p_first;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      hi_a     <= '0;
      lo_a     <= '0;
      byp_a    <= 1'b0;
      fix_a    <= 1'b0;
      started  <= 1'b0;
      pos_q    <= 1'b0;
      pos_cnt  <= '0;
      wait_cnt <= '0;
    end else if (sync) begin
      started  <= 1'b0;
      wait_cnt <= phase_ofs;
      pos_q    <= 1'b0;
      fix_a    <= 1'b0;
      pos_cnt  <= '0;
    end else if (load) begin
      started <= 1'b1;
      hi_a    <= hi_cnt;
      lo_a    <= lo_cnt;
      byp_a   <= bypass;
      fix_a   <= fix_req && !bypass;
      pos_cnt <= '0;
      pos_q   <= !bypass;
    end else if (!started) begin
      wait_cnt <= wait_cnt - PW'(1);
    end else begin
      pos_cnt <= pos_cnt + DW'(1);
      pos_q   <= pos_cnt < DW'(hi_a);
    end
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pos_q;
  end

  assign clk_out = (started && byp_a) ? clk_in : (pos_q | (fix_a & neg_q));

  a_r6_sync_forces_low: assert property (@(posedge clk_in) disable iff (!rst_n)
    sync |=> (!started && !pos_q && !fix_a));

  a_r2_count_in_period: assert property (@(posedge clk_in) disable iff (!rst_n)
    (started && !byp_a) |-> (pos_cnt <= d_last));

  a_r7_cfg_held_mid_period: assert property (@(posedge clk_in) disable iff (!rst_n)
    (started && pos_cnt != '0) |-> ($stable(hi_a) && $stable(lo_a) && $stable(byp_a) && $stable(fix_a)));

  a_r5_bypass_counter_idle: assert property (@(posedge clk_in) disable iff (!rst_n)
    (started && byp_a && !sync) |=> (pos_cnt == '0));

  a_r4_fix_only_odd_pair: assert property (@(posedge clk_in) disable iff (!rst_n)
    fix_a |-> (((CW+1)'(lo_a) == (CW+1)'(hi_a) + (CW+1)'(1)) && !byp_a));
endmodule

// File: tb/clk_chan_div_tb.sv
module clk_chan_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] hi = 4'd1, lo = 4'd1;
  logic       byp = 1'b0, doff = 1'b0, sy = 1'b0;
  logic [4:0] ofs = 5'd0;
  logic       clk_out;
  int         checks = 0, errors = 0;
  string      cur_req = "R1";

  always #4 clk = ~clk;

  clk_chan_div #(.CW(4), .PW(5)) dut_i (
    .clk_in(clk), .rst_n(rst_n), .hi_cnt(hi), .lo_cnt(lo), .bypass(byp),
    .dcc_off(doff), .phase_ofs(ofs), .sync(sy), .clk_out(clk_out));

  // behavioural reference: where are we in the output waveform
  int  m_hi, m_lo, m_pos_idx, m_wait;
  bit  m_byp, m_fix, m_run, m_high, m_ext;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_byp = 0; m_fix = 0; m_run = 0; m_high = 0;
      m_pos_idx = 0; m_wait = 0;
    end else if (sy) begin
      m_run = 0; m_wait = ofs; m_high = 0; m_fix = 0; m_pos_idx = 0;
    end else if ((m_run && (m_byp || m_pos_idx == m_hi + m_lo + 1)) || (!m_run && m_wait == 0)) begin
      m_run = 1; m_hi = hi; m_lo = lo; m_byp = byp;
      m_fix = !byp && !doff && (lo == hi + 1);
      m_pos_idx = 0; m_high = !byp;
    end else if (!m_run) begin
      m_wait = m_wait - 1;
    end else begin
      m_pos_idx = m_pos_idx + 1;
      m_high = (m_pos_idx <= m_hi);
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) m_ext = 0;
    else        m_ext = m_high;
  end

  function automatic bit expect_out(bit first_half);
    if (m_run && m_byp) return first_half;
    return m_high | (m_fix & m_ext);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    check(clk_out == expect_out(1'b1), cur_req, "model high-half", clk_out, expect_out(1'b1));
  end
  always @(negedge clk) begin
    #2;
    check(clk_out == expect_out(1'b0), cur_req, "model low-half", clk_out, expect_out(1'b0));
  end

  task automatic set_cfg(int h, int l, bit b, bit d);
    @(negedge clk); #1;
    hi = 4'(h); lo = 4'(l); byp = b; doff = d;
  endtask

  task automatic measure(output int per, output int hh);
    bit prev, a;
    int guard;
    per = 0; hh = 0; guard = 0;
    @(negedge clk); #2 prev = clk_out;
    forever begin
      @(posedge clk); #2 a = clk_out;
      if (!prev && a) break;
      @(negedge clk); #2 prev = clk_out;
      guard++;
      if (guard > 80) break;
    end
    hh = 1;
    forever begin
      @(negedge clk); #2 prev = clk_out;
      if (prev) hh++;
      @(posedge clk); #2 a = clk_out;
      per++;
      if (!prev && a) break;
      if (a) hh++;
      if (per > 40) break;
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int per, hh, k;
    cur_req = "R1";
    repeat (4) @(negedge clk);
    #3 check(clk_out == 1'b0, "R1", "output low in reset", clk_out, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #2 check(clk_out == 1'b1, "R1", "first edge after reset high", clk_out, 1);

    cur_req = "R2/R3/R8";
    for (int n = 0; n < 16; n++)
      for (int m = 0; m < 16; m++) begin
        set_cfg(n, m, 1'b0, 1'b1);
        measure(per, hh);
        check(per == n + m + 2, "R2", "period dcc off", per, n + m + 2);
        check(hh == 2 * (n + 1), (m == n + 1) ? "R8" : "R3", "high halves dcc off", hh, 2 * (n + 1));
      end

    cur_req = "R2/R3/R4";
    for (int n = 0; n < 16; n++)
      for (int m = 0; m < 16; m++) begin
        set_cfg(n, m, 1'b0, 1'b0);
        measure(per, hh);
        check(per == n + m + 2, "R2", "period dcc on", per, n + m + 2);
        if (m == n + 1)
          check(hh == n + m + 2, "R4", "odd corrected high halves", hh, n + m + 2);
        else
          check(hh == 2 * (n + 1), "R3", "high halves dcc on", hh, 2 * (n + 1));
      end

    cur_req = "R5";
    set_cfg(3, 4, 1'b1, 1'b0);
    measure(per, hh);
    measure(per, hh);
    check(per == 1, "R5", "bypass period", per, 1);
    check(hh == 1, "R5", "bypass high halves", hh, 1);
    set_cfg(2, 2, 1'b0, 1'b0);
    measure(per, hh);
    check(per == 6, "R5", "leaving bypass period", per, 6);

    cur_req = "R7";
    set_cfg(7, 7, 1'b0, 1'b1);
    measure(per, hh);
    repeat (3) @(posedge clk);
    set_cfg(1, 1, 1'b1, 1'b0);
    repeat (20) @(posedge clk);
    set_cfg(5, 9, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    set_cfg(0, 1, 1'b0, 1'b0);
    repeat (40) @(posedge clk);

    cur_req = "R6";
    set_cfg(2, 3, 1'b0, 1'b1);
    foreach (ofs_list[i]) begin
      @(negedge clk); #1 ofs = 5'(ofs_list[i]); sy = 1'b1;
      @(posedge clk); #2 check(clk_out == 1'b0, "R6", "low after sync edge", clk_out, 0);
      @(negedge clk); #1 sy = 1'b0;
      k = 1;
      while (k < 40) begin
        @(posedge clk); #2 k++;
        if (clk_out) break;
      end
      check(k == ofs_list[i] + 2, "R6", "edges from sync to rise", k, ofs_list[i] + 2);
      repeat (7) @(posedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int ofs_list[4] = '{0, 3, 7, 31};
endmodule